// File: doc/BRIEF.md
# Four-Way Write-Back Data Cache

This block is a data cache that sits between a processor load/store port and a word-wide backing memory. It has four ways per set. Each way holds a single 32-bit word, together with a valid flag, a dirty flag and a tag. Stores are write-back and write-allocate. A store that hits changes only the cache copy. A miss reads the word in from memory. If the line being replaced is dirty, that line is first written back.

The processor side uses a valid/ready handshake. The processor raises `cpu_valid` and holds `cpu_we`, `cpu_addr` and `cpu_wdata` stable until it samples `cpu_ready` high at a clock edge. That edge completes the access. In that cycle `cpu_rdata` carries the load result, and `cpu_hit` reports whether the access was served without touching memory. A hit completes in the cycle it is presented. A miss back-pressures the processor by holding `cpu_ready` low until the fill is installed.

The memory side uses a request/acknowledge handshake. `mem_req` stays high, with address, direction and write data stable, until memory returns a one-cycle `mem_ack`. For a read, memory places the word on `mem_rdata` in the ack cycle. Memory may stall any number of cycles.

Top module: `dcache_wb4`

## Requirements
- R1: After reset every line is invalid: `cpu_ready`, `cpu_hit` and `mem_req` are low, and the first access to any address is a miss.
- R2: The address splits into byte offset [1:0], set index [9:2] and tag [31:10]. Addresses that differ only in bits [1:0] hit the same line.
- R3: A load to a resident line completes in the cycle it is presented, with `cpu_ready`=1, `cpu_hit`=1, the stored word on `cpu_rdata`, and no memory request.
- R4: A store hit writes only the cache, with no memory traffic. It marks the line dirty. A later load returns the stored word.
- R5: A miss whose victim is clean or invalid issues exactly one memory read, at `{tag, set, 2'b00}`. A load miss returns the read word and installs it clean.
- R6: A store miss first reads the block from memory. It then installs the store data instead of the read word, marks the line dirty, and does not write memory.
- R7: A miss whose victim is valid and dirty first writes the victim word to `{victim tag, set, 2'b00}`. Only then does it issue the fill read.
- R8: The victim is the lowest-numbered invalid way of the set. When all four ways are valid, the victim is taken from a per-set 2-bit round-robin pointer. The pointer starts at way 0 and advances by one on each replacement in a full set.
- R9: `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` stay stable from the rise of a request until its one-cycle `mem_ack`.
- R10: `cpu_ready` is low from the cycle a miss is presented until the cycle after the last `mem_ack`. In that completing cycle `cpu_ready`=1 and `cpu_hit`=0, so a miss takes 1 + (memory operations × (1 + memory stall)) cycles with ready low.
- R11: Four different tags can be resident in one set at the same time, and all four hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | Processor request present |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Store data |
| cpu_ready | output | 1 | Access completes at this edge |
| cpu_hit | output | 1 | Completing access was served without memory |
| cpu_rdata | output | 32 | Load data, valid while `cpu_ready` is high |
| mem_req | output | 1 | Memory request pending |
| mem_we | output | 1 | 1 = writeback, 0 = fill read |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_wdata | output | 32 | Writeback data |
| mem_ack | input | 1 | One-cycle acknowledge of the pending request |
| mem_rdata | input | 32 | Fill data, valid with `mem_ack` |

## Verification
A hit is due in the same cycle it is presented. The bench samples one time unit after the driving falling edge and expects zero cycles of low ready. A miss's memory request appears one cycle after presentation. Each request is acknowledged after a chosen stall of 0 to 2 cycles. Completion is due one cycle after the last acknowledge. The bench counts the low-ready cycles of every access and compares the count with 1 + ops × (1 + stall), where ops is 1 or 2 depending on whether a dirty victim is expected. Data, hit flag, writeback address and data, and fill address are checked at the same sample points.

// File: rtl/dc_pkg.sv
package dc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WB   = 2'd1,
    ST_FILL = 2'd2,
    ST_DONE = 2'd3
  } dc_state_t;
endpackage

// File: rtl/dc_store.sv
module dc_store #(
  parameter  int SETS  = 256,
  parameter  int WAYS  = 4,
  parameter  int TAG_W = 22,
  parameter  int DW    = 32,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [IDX_W-1:0]            rd_idx,
  output logic [WAYS-1:0]             rd_valid,
  output logic [WAYS-1:0]             rd_dirty,
  output logic [WAYS-1:0][TAG_W-1:0]  rd_tag,
  output logic [WAYS-1:0][DW-1:0]     rd_data,
  input  logic                        wr_en,
  input  logic [IDX_W-1:0]            wr_idx,
  input  logic [WAY_W-1:0]            wr_way,
  input  logic [TAG_W-1:0]            wr_tag,
  input  logic [DW-1:0]               wr_data,
  input  logic                        wr_dirty
);
  logic [WAYS-1:0]  vld_q [SETS];
  logic [WAYS-1:0]  dty_q [SETS];
  logic [TAG_W-1:0] tag_q [SETS][WAYS];
  logic [DW-1:0]    dat_q [SETS][WAYS];

  // flags carry reset; payload arrays do not need it
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s] <= '0;
        dty_q[s] <= '0;
      end
    end else if (wr_en) begin
      vld_q[wr_idx][wr_way] <= 1'b1;
      dty_q[wr_idx][wr_way] <= wr_dirty;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx][wr_way] <= wr_tag;
      dat_q[wr_idx][wr_way] <= wr_data;
    end
  end

  assign rd_valid = vld_q[rd_idx];
  assign rd_dirty = dty_q[rd_idx];

  for (genvar w = 0; w < WAYS; w++) begin : g_rd
    assign rd_tag[w]  = tag_q[rd_idx][w];
    assign rd_data[w] = dat_q[rd_idx][w];
  end
endmodule

// File: rtl/dc_lookup.sv
module dc_lookup #(
  parameter  int WAYS  = 4,
  parameter  int TAG_W = 22,
  parameter  int DW    = 32,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]            way_valid,
  input  logic [WAYS-1:0][TAG_W-1:0] way_tag,
  input  logic [WAYS-1:0][DW-1:0]    way_data,
  input  logic [TAG_W-1:0]           tag,
  output logic                       hit,
  output logic [WAY_W-1:0]           hit_way,
  output logic [DW-1:0]              hit_data
);
  logic [WAYS-1:0] match;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match[w] = way_valid[w] && (way_tag[w] == tag);
  end

  assign hit = |match;

  // one-hot match: OR-select data and encode the way
  always_comb begin
    hit_way  = '0;
    hit_data = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (match[w]) begin
        hit_way  = hit_way | WAY_W'(w);
        hit_data = hit_data | way_data[w];
      end
    end
  end
endmodule

// File: rtl/dc_victim.sv
module dc_victim #(
  parameter  int SETS  = 256,
  parameter  int WAYS  = 4,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] idx,
  input  logic [WAYS-1:0]  way_valid,
  input  logic             replace,
  output logic [WAY_W-1:0] victim
);
  logic [WAY_W-1:0] rr_q [SETS];
  logic             any_free;

  always_comb begin
    victim   = rr_q[idx];
    any_free = 1'b0;
    for (int w = WAYS-1; w >= 0; w--) begin
      if (!way_valid[w]) begin
        victim   = WAY_W'(w);
        any_free = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) rr_q[s] <= '0;
    end else if (replace && !any_free) begin
      rr_q[idx] <= rr_q[idx] + 1'b1;
    end
  end
endmodule

// File: rtl/dc_ctrl.sv
module dc_ctrl
  import dc_pkg::*;
#(
  parameter  int WAYS  = 4,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_valid,
  input  logic             cpu_we,
  input  logic             hit,
  input  logic [WAY_W-1:0] vic_way,
  input  logic             vic_evict,
  input  logic             mem_ack,
  output dc_state_t        state,
  output logic [WAY_W-1:0] way_q,
  output logic             mem_req,
  output logic             mem_we,
  output logic             cpu_ready,
  output logic             cpu_hit,
  output logic             store_hit,
  output logic             fill_done
);
  dc_state_t state_d;
  logic      idle_hit;

  assign idle_hit = (state == ST_IDLE) && cpu_valid && hit;

  always_comb begin
    state_d = state;
    unique case (state)
      ST_IDLE: if (cpu_valid && !hit) state_d = vic_evict ? ST_WB : ST_FILL;
      ST_WB:   if (mem_ack) state_d = ST_FILL;
      ST_FILL: if (mem_ack) state_d = ST_DONE;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      way_q <= '0;
    end else begin
      state <= state_d;
      if (state == ST_IDLE && cpu_valid && !hit) way_q <= vic_way;
    end
  end

  assign mem_req   = (state == ST_WB) || (state == ST_FILL);
  assign mem_we    = (state == ST_WB);
  assign cpu_ready = idle_hit || (state == ST_DONE);
  assign cpu_hit   = idle_hit;
  assign store_hit = idle_hit && cpu_we;
  assign fill_done = (state == ST_FILL) && mem_ack;
endmodule

// File: rtl/dcache_wb4.sv
module dcache_wb4
  import dc_pkg::*;
#(
  parameter  int AW    = 32,
  parameter  int DW    = 32,
  parameter  int SETS  = 256,
  parameter  int WAYS  = 4,
  localparam int OFF_W = $clog2(DW/8),
  localparam int IDX_W = $clog2(SETS),
  localparam int TAG_W = AW - IDX_W - OFF_W,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_valid,
  input  logic          cpu_we,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  output logic          cpu_ready,
  output logic          cpu_hit,
  output logic [DW-1:0] cpu_rdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata
);
  logic [IDX_W-1:0]            idx;
  logic [TAG_W-1:0]            tag;
  logic                        unused_off;
  logic [WAYS-1:0]             rd_valid, rd_dirty;
  logic [WAYS-1:0][TAG_W-1:0]  rd_tag;
  logic [WAYS-1:0][DW-1:0]     rd_data;
  logic                        hit;
  logic [WAY_W-1:0]            hit_way, vic_way, way_q;
  logic [DW-1:0]               hit_data;
  logic                        vic_evict, store_hit, fill_done;
  logic                        wr_en, wr_dirty;
  logic [WAY_W-1:0]            wr_way;
  logic [DW-1:0]               wr_data;
  dc_state_t                   state;

  assign idx        = cpu_addr[OFF_W +: IDX_W];
  assign tag        = cpu_addr[AW-1 -: TAG_W];
  assign unused_off = ^cpu_addr[OFF_W-1:0];

  dc_store #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .DW(DW)) u_store (
    .clk(clk), .rst_n(rst_n), .rd_idx(idx),
    .rd_valid(rd_valid), .rd_dirty(rd_dirty), .rd_tag(rd_tag), .rd_data(rd_data),
    .wr_en(wr_en), .wr_idx(idx), .wr_way(wr_way), .wr_tag(tag),
    .wr_data(wr_data), .wr_dirty(wr_dirty)
  );

  dc_lookup #(.WAYS(WAYS), .TAG_W(TAG_W), .DW(DW)) u_lookup (
    .way_valid(rd_valid), .way_tag(rd_tag), .way_data(rd_data), .tag(tag),
    .hit(hit), .hit_way(hit_way), .hit_data(hit_data)
  );

  dc_victim #(.SETS(SETS), .WAYS(WAYS)) u_victim (
    .clk(clk), .rst_n(rst_n), .idx(idx), .way_valid(rd_valid),
    .replace(fill_done), .victim(vic_way)
  );

  assign vic_evict = rd_valid[vic_way] && rd_dirty[vic_way];

  dc_ctrl #(.WAYS(WAYS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_we(cpu_we),
    .hit(hit), .vic_way(vic_way), .vic_evict(vic_evict), .mem_ack(mem_ack),
    .state(state), .way_q(way_q), .mem_req(mem_req), .mem_we(mem_we),
    .cpu_ready(cpu_ready), .cpu_hit(cpu_hit), .store_hit(store_hit),
    .fill_done(fill_done)
  );

  // single write port: store hit or fill install (store data wins on store miss)
  assign wr_en    = store_hit || fill_done;
  assign wr_way   = fill_done ? way_q : hit_way;
  assign wr_data  = (fill_done && !cpu_we) ? mem_rdata : cpu_wdata;
  assign wr_dirty = cpu_we;

  assign cpu_rdata = hit_data;
  assign mem_wdata = rd_data[way_q];
  assign mem_addr  = (state == ST_WB) ? {rd_tag[way_q], idx, {OFF_W{1'b0}}}
                                      : {tag, idx, {OFF_W{1'b0}}};
endmodule

// File: rtl/dc_chk.sv
module dc_chk #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] cpu_addr,
  input logic          cpu_ready,
  input logic          cpu_hit,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic          mem_ack
);
  AST_HIT_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_hit |-> cpu_ready && !mem_req); // R3
  AST_FILL_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_we |-> mem_addr == {cpu_addr[AW-1:2], 2'b00}); // R5
  AST_WB_THEN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we && mem_ack |=> mem_req && !mem_we); // R7
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_we) && $stable(mem_addr)
                            && $stable(mem_wdata)); // R9
  AST_MISS_READY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !cpu_ready); // R10
  AST_FILL_COMPLETES: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_we && mem_ack |=> cpu_ready && !cpu_hit); // R10
endmodule

bind dcache_wb4 dc_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_ready(cpu_ready),
  .cpu_hit(cpu_hit), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .mem_ack(mem_ack)
);

// File: tb/sim_dcache_wb4.sv
module sim_dcache_wb4;
  localparam int SETS = 256;
  localparam int WAYS = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        cpu_valid = 1'b0, cpu_we = 1'b0;
  logic [31:0] cpu_addr = '0, cpu_wdata = '0;
  logic        cpu_ready, cpu_hit;
  logic [31:0] cpu_rdata;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;

  dcache_wb4 u0 (
    .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready),
    .cpu_hit(cpu_hit), .cpu_rdata(cpu_rdata), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  int n_chk = 0, n_fail = 0, lat = 0;

  logic [31:0] mem_img [logic [31:0]];
  bit          m_v [SETS][WAYS];
  bit          m_d [SETS][WAYS];
  logic [21:0] m_t [SETS][WAYS];
  logic [31:0] m_dat [SETS][WAYS];
  logic [1:0]  m_rr [SETS];

  function automatic logic [31:0] mem_val(input logic [31:0] a);
    if (mem_img.exists(a)) return mem_img[a];
    return (a * 32'h9E37_79B9) ^ 32'h5A5A_C3C3;
  endfunction

  task automatic check(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic access(input bit we, input logic [31:0] a, input logic [31:0] wd,
                        input string rq);
    logic [7:0]  idx = a[9:2];
    logic [21:0] tg  = a[31:10];
    int hw = -1, v = -1, low = 0, wbn = 0, filln = 0, waitc = 0;
    bit ewb = 0, order_ok = 1, h = 0;
    logic [31:0] ewba = '0, ewbd = '0, efa, fillv, exp_rd = '0;
    logic [31:0] wba = '0, wbd = '0, fa = '0, rd = '0, first_a = '0;
    int exp_low;
    // reference model
    for (int w = 0; w < WAYS; w++) if (m_v[idx][w] && m_t[idx][w] == tg) hw = w;
    efa = {tg, idx, 2'b00};
    if (hw >= 0) begin
      exp_rd = m_dat[idx][hw];
      if (we) begin m_dat[idx][hw] = wd; m_d[idx][hw] = 1; end
    end else begin
      for (int w = 0; w < WAYS; w++) if (!m_v[idx][w] && v < 0) v = w;
      if (v < 0) begin v = int'(m_rr[idx]); m_rr[idx] = m_rr[idx] + 2'd1; end
      ewb  = m_v[idx][v] && m_d[idx][v];
      ewba = {m_t[idx][v], idx, 2'b00};
      ewbd = m_dat[idx][v];
      fillv = mem_val(efa);
      exp_rd = fillv;
      m_v[idx][v] = 1; m_t[idx][v] = tg; m_d[idx][v] = we;
      m_dat[idx][v] = we ? wd : fillv;
    end
    exp_low = (hw >= 0) ? 0 : 1 + (int'(ewb) + 1) * (lat + 1);

    @(negedge clk);
    cpu_valid = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
    forever begin
      #1;
      if (cpu_ready) begin h = cpu_hit; rd = cpu_rdata; break; end
      low++;
      if (low > 40) break;
      if (mem_req) begin
        if (waitc == 0) first_a = mem_addr;
        if (waitc == lat) begin
          check(mem_addr == first_a, "R9", "address held until ack", mem_addr, first_a);
          if (mem_we) begin
            wbn++; wba = mem_addr; wbd = mem_wdata;
            mem_img[mem_addr] = mem_wdata;
            if (filln > 0) order_ok = 0;
          end else begin
            filln++; fa = mem_addr; mem_rdata = mem_val(mem_addr);
          end
          mem_ack = 1'b1;
          waitc = 0;
        end else waitc++;
      end
      @(negedge clk);
      mem_ack = 1'b0;
    end
    @(posedge clk); #1;
    cpu_valid = 1'b0;

    check(h == (hw >= 0), rq, "hit flag", 32'(h), 32'(hw >= 0));
    check(low == exp_low, "R10", "cycles with ready low", low, exp_low);
    check(wbn == int'(ewb), "R7", "writeback count", wbn, 32'(ewb));
    if (ewb) begin
      check(wba == ewba, "R7", "writeback address", wba, ewba);
      check(wbd == ewbd, "R7", "writeback data", wbd, ewbd);
      check(order_ok, "R7", "writeback before fill", 32'(order_ok), 1);
    end
    check(filln == ((hw >= 0) ? 0 : 1), rq, "fill count", filln, (hw >= 0) ? 0 : 1);
    if (hw < 0) check(fa == efa, "R5", "fill address", fa, efa);
    if (!we) check(rd == exp_rd, rq, "load data", rd, exp_rd);
  endtask

  function automatic logic [31:0] mk(input int t, input int s, input int off);
    return {22'(t), 8'(s), 2'(off)};
  endfunction

  initial begin
    #(8 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] x = 32'h1234_5679;
    for (int s = 0; s < SETS; s++) begin
      m_rr[s] = '0;
      for (int w = 0; w < WAYS; w++) begin m_v[s][w] = 0; m_d[s][w] = 0; end
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk); #1;
    check(!cpu_ready && !cpu_hit && !mem_req, "R1", "idle outputs after reset",
          {29'd0, cpu_ready, cpu_hit, mem_req}, 0);

    // R1: every set misses once after reset
    lat = 0;
    for (int s = 0; s < SETS; s++) access(0, mk(1, s, 0), 0, "R1");
    // R2: same lines hit with any byte offset
    for (int s = 0; s < SETS; s++) access(0, mk(1, s, s % 4), 0, "R2");
    // R11: four tags in set 5
    for (int t = 2; t <= 4; t++) access(0, mk(t, 5, 0), 0, "R11");
    for (int t = 1; t <= 4; t++) access(0, mk(t, 5, 3), 0, "R11");
    // R4: store hits, then read back
    access(1, mk(1, 5, 0), 32'hDEAD_0001, "R4");
    access(1, mk(3, 5, 1), 32'hDEAD_0003, "R4");
    access(0, mk(1, 5, 2), 0, "R4");
    access(0, mk(3, 5, 0), 0, "R4");
    // R8: round-robin replacement in a full set, dirty victims written back
    lat = 2;
    access(0, mk(9, 5, 0), 0, "R8");
    access(0, mk(10, 5, 0), 0, "R8");
    access(0, mk(11, 5, 0), 0, "R8");
    access(0, mk(12, 5, 0), 0, "R8");
    access(0, mk(13, 5, 0), 0, "R8");
    // R6: store miss allocates, dirty data later written back
    lat = 1;
    access(1, mk(20, 7, 0), 32'hCAFE_0020, "R6");
    access(0, mk(20, 7, 0), 0, "R6");
    for (int t = 21; t <= 24; t++) access(0, mk(t, 7, 0), 0, "R6");
    // mixed sweep over a small set/tag space with varying memory stall
    for (int i = 0; i < 3000; i++) begin
      x ^= x << 13; x ^= x >> 17; x ^= x << 5;
      lat = i % 3;
      access(x[0], mk(int'(x[6:4]), 16 + int'(x[9:8]), int'(x[11:10])),
             {x[31:16], x[15:0] ^ 16'hA5A5}, "R8");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule